// File: doc/BRIEF.md
# Paired Arithmetic Units with Shared Carry

This block executes one instruction per cycle on two 32-bit arithmetic units that run in a fixed order. The first unit computes before the second. The second unit sees any register the first one wrote in the same instruction. It also sees a carry/high register that the first one may have just updated. Through this shared register, one instruction can do a 64-bit add, subtract or multiply split across the two units.

Each unit selects two operands from a 24-entry register file, a constant zero, its own immediate, the other unit's immediate, a 32-bit immediate built from both, or one of two load words. It computes a result from a 5-bit opcode and may write it to a register. Results and write enables appear one cycle after the instruction is accepted.

Opcodes that read a state table, read or write a scratch memory, or request a synchronisation barrier leave the block as request ports. The returned data comes back on read-data inputs in the same cycle.

Top module: `dual_alu_exec`

## Requirements
- R1: Each cycle with `in_valid` high is one instruction. On the next rising edge `out_valid` rises, and `res0`/`res1` and the write flags take that instruction's values. A cycle with `in_valid` low gives `out_valid` low, clears both write flags and writes no register.
- R2: Operand select codes are: 0–23 for registers r0–r23, 24 for zero, 25 for the unit's own immediate sign-extended, 26 for the other unit's immediate sign-extended, 27 for `{imm0, imm1}`, 28 for `ld0` and 29 for `ld1`.
- R3: A destination code below 24 writes that register, and the write is visible to unit 1 in the same instruction and to later instructions. A destination code of 24 or above is discarded and its write flag stays low.
- R4: Opcode ADD (0) sets carry to the unsigned overflow of x+y. ADDC (1) returns x+y+carry and leaves carry unchanged.
- R5: SUB (2) sets carry to the borrow (x<y unsigned). SUBB (3) returns x−y−carry and leaves carry unchanged.
- R6: MUL (4) is a signed 32×32 product and MULU (5) an unsigned one. Each returns the low word and loads the high word into carry. MULH (6) returns carry.
- R7: SLL (8), SRL (9) and SRA (10) shift x by y[4:0] only.
- R8: CLZ (7) returns the number of leading zeros of x, and 32 when x is zero.
- R9: AND (11), NAND (12), OR (13) and XOR (14) are bitwise.
- R10: MERGE (15) reads the unit's immediate as destination position [15:10], width [9:5] and source position [4:0]. It returns x with the width-bit field at the destination position replaced by the field of y at the source position. Bits moved past bit 31 are dropped.
- R11: SLT (16) and SLE (18) compare signed, SLTU (17) and SLEU (19) compare unsigned, and SEQ (20) tests equality. Each returns all ones when true and zero when false.
- R12: STATE (21) raises `state_req` with `state_addr` = ((x+y) mod 65536)·4 and returns `state_rdata`. At most one unit per instruction may use STATE.
- R13: MRD (22) raises `mem_rd_req` with `mem_addr`=x and returns `mem_rdata`. MWR (23) raises `mem_wr_req` with `mem_addr`=x and `mem_wdata`=y. SYNC (24) raises `sync_req`. Unit 0 has priority on the memory port. No request is raised while `in_valid` is low.
- R14: Reset clears the registers, the carry and the outputs. Carry keeps its value across instructions that do not set it and across idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction present this cycle |
| op0 | input | 5 | Unit 0 opcode |
| op1 | input | 5 | Unit 1 opcode |
| sa0 | input | 5 | Unit 0 operand x select |
| sb0 | input | 5 | Unit 0 operand y select |
| sa1 | input | 5 | Unit 1 operand x select |
| sb1 | input | 5 | Unit 1 operand y select |
| dst0 | input | 5 | Unit 0 destination |
| dst1 | input | 5 | Unit 1 destination |
| imm0 | input | 16 | Unit 0 immediate |
| imm1 | input | 16 | Unit 1 immediate |
| ld0 | input | 32 | First load word |
| ld1 | input | 32 | Second load word |
| state_req | output | 1 | State read request |
| state_addr | output | 18 | State byte address |
| state_rdata | input | 32 | State read data |
| mem_rd_req | output | 1 | Scratch memory read request |
| mem_wr_req | output | 1 | Scratch memory write request |
| mem_addr | output | 32 | Scratch memory index |
| mem_wdata | output | 32 | Scratch memory write data |
| mem_rdata | input | 32 | Scratch memory read data |
| sync_req | output | 1 | Barrier request |
| out_valid | output | 1 | Results valid |
| res0 | output | 32 | Unit 0 result |
| res1 | output | 32 | Unit 1 result |
| wr0_en | output | 1 | Unit 0 wrote a register |
| wr0_idx | output | 5 | Unit 0 destination index |
| wr1_en | output | 1 | Unit 1 wrote a register |
| wr1_idx | output | 5 | Unit 1 destination index |

## Verification
Carry chaining is tried with operand pairs that do and do not overflow or borrow. A stuck or wrong-direction carry then shows up in the second unit's result. Signed and unsigned multiplies use a negative immediate, so a sign-extension fault changes the high word. Shifts use amounts above 31, and comparisons use -1 against 1, to separate signed from unsigned paths and masked from unmasked shift counts. Directed sequences cover same-instruction forwarding, discarded destinations, idle cycles that must hold carry and registers, and the request ports.

// File: rtl/dalu_pkg.sv
package dalu_pkg;
    localparam int DW    = 32;
    localparam int IMM_W = 16;
    localparam int OP_W  = 5;
    localparam int SEL_W = 5;
    localparam int NREGS = 24;
    localparam int ST_AW = IMM_W + 2;

    typedef enum logic [OP_W-1:0] {
        OP_ADD   = 5'd0,
        OP_ADDC  = 5'd1,
        OP_SUB   = 5'd2,
        OP_SUBB  = 5'd3,
        OP_MUL   = 5'd4,
        OP_MULU  = 5'd5,
        OP_MULH  = 5'd6,
        OP_CLZ   = 5'd7,
        OP_SLL   = 5'd8,
        OP_SRL   = 5'd9,
        OP_SRA   = 5'd10,
        OP_AND   = 5'd11,
        OP_NAND  = 5'd12,
        OP_OR    = 5'd13,
        OP_XOR   = 5'd14,
        OP_MERGE = 5'd15,
        OP_SLT   = 5'd16,
        OP_SLTU  = 5'd17,
        OP_SLE   = 5'd18,
        OP_SLEU  = 5'd19,
        OP_SEQ   = 5'd20,
        OP_STATE = 5'd21,
        OP_MRD   = 5'd22,
        OP_MWR   = 5'd23,
        OP_SYNC  = 5'd24
    } alu_op_e;
endpackage

// File: rtl/dalu_operand.sv
module dalu_operand #(
    parameter int DW    = 32,
    parameter int IMM_W = 16,
    parameter int SEL_W = 5,
    parameter int NREGS = 24
) (
    input  logic [SEL_W-1:0]           sel,
    input  logic [NREGS-1:0][DW-1:0]   regs,
    input  logic [IMM_W-1:0]           imm_own,
    input  logic [IMM_W-1:0]           imm_other,
    input  logic [IMM_W-1:0]           imm_hi,
    input  logic [IMM_W-1:0]           imm_lo,
    input  logic [DW-1:0]              ld0,
    input  logic [DW-1:0]              ld1,
    output logic [DW-1:0]              val
);
    localparam int SEL_ZERO = NREGS;
    localparam int SEL_IMM  = NREGS + 1;
    localparam int SEL_PAIR = NREGS + 2;
    localparam int SEL_WIDE = NREGS + 3;
    localparam int SEL_LD0  = NREGS + 4;
    localparam int SEL_LD1  = NREGS + 5;

    always_comb begin
        val = '0;
        for (int i = 0; i < NREGS; i++) begin
            if (sel == SEL_W'(i)) val = regs[i];
        end
        if (sel == SEL_W'(SEL_IMM))
            val = {{(DW-IMM_W){imm_own[IMM_W-1]}}, imm_own};
        else if (sel == SEL_W'(SEL_PAIR))
            val = {{(DW-IMM_W){imm_other[IMM_W-1]}}, imm_other};
        else if (sel == SEL_W'(SEL_WIDE))
            val = DW'({imm_hi, imm_lo});
        else if (sel == SEL_W'(SEL_LD0))
            val = ld0;
        else if (sel == SEL_W'(SEL_LD1))
            val = ld1;
        else if (sel == SEL_W'(SEL_ZERO))
            val = '0;
    end
endmodule

// File: rtl/dalu_core.sv
module dalu_core
    import dalu_pkg::*;
(
    input  alu_op_e          op,
    input  logic [DW-1:0]    x,
    input  logic [DW-1:0]    y,
    input  logic [IMM_W-1:0] imm,
    input  logic [DW-1:0]    carry_in,
    input  logic [DW-1:0]    state_rdata,
    input  logic [DW-1:0]    mem_rdata,
    output logic [DW-1:0]    res,
    output logic             carry_we,
    output logic [DW-1:0]    carry_nx
);
    localparam int SH_W = $clog2(DW);
    localparam int WW   = 2 * DW;

    logic [SH_W-1:0] sh;
    logic [DW:0]     add_full;
    logic [WW-1:0]   prod_s, prod_u;
    logic [5:0]      m_dpos;
    logic [4:0]      m_wid, m_spos;
    logic [WW-1:0]   m_mask, m_field, m_hole;

    function automatic logic [DW-1:0] lead_zeros(input logic [DW-1:0] v);
        logic found;
        lead_zeros = DW'(DW);
        found = 1'b0;
        for (int i = DW - 1; i >= 0; i--) begin
            if (!found && v[i]) begin
                lead_zeros = DW'(DW - 1 - i);
                found = 1'b1;
            end
        end
    endfunction

    always_comb begin
        sh       = y[SH_W-1:0];
        add_full = {1'b0, x} + {1'b0, y};
        prod_s   = {{DW{x[DW-1]}}, x} * {{DW{y[DW-1]}}, y};
        prod_u   = {{DW{1'b0}}, x} * {{DW{1'b0}}, y};
        m_dpos   = imm[15:10];
        m_wid    = imm[9:5];
        m_spos   = imm[4:0];
        m_mask   = (WW'(1) << m_wid) - WW'(1);
        m_field  = ((({{DW{1'b0}}, y}) >> m_spos) & m_mask) << m_dpos;
        m_hole   = ~(m_mask << m_dpos);

        res      = '0;
        carry_we = 1'b0;
        carry_nx = '0;
        case (op)
            OP_ADD: begin
                res      = add_full[DW-1:0];
                carry_we = 1'b1;
                carry_nx = DW'(add_full[DW]);
            end
            OP_ADDC:  res = x + y + carry_in;
            OP_SUB: begin
                res      = x - y;
                carry_we = 1'b1;
                carry_nx = DW'(x < y);
            end
            OP_SUBB:  res = x - y - carry_in;
            OP_MUL: begin
                res      = prod_s[DW-1:0];
                carry_we = 1'b1;
                carry_nx = prod_s[WW-1:DW];
            end
            OP_MULU: begin
                res      = prod_u[DW-1:0];
                carry_we = 1'b1;
                carry_nx = prod_u[WW-1:DW];
            end
            OP_MULH:  res = carry_in;
            OP_CLZ:   res = lead_zeros(x);
            OP_SLL:   res = x << sh;
            OP_SRL:   res = x >> sh;
            OP_SRA:   res = $unsigned($signed(x) >>> sh);
            OP_AND:   res = x & y;
            OP_NAND:  res = ~(x & y);
            OP_OR:    res = x | y;
            OP_XOR:   res = x ^ y;
            OP_MERGE: res = (x & m_hole[DW-1:0]) | m_field[DW-1:0];
            OP_SLT:   res = {DW{$signed(x) < $signed(y)}};
            OP_SLTU:  res = {DW{x < y}};
            OP_SLE:   res = {DW{$signed(x) <= $signed(y)}};
            OP_SLEU:  res = {DW{x <= y}};
            OP_SEQ:   res = {DW{x == y}};
            OP_STATE: res = state_rdata;
            OP_MRD:   res = mem_rdata;
            default:  res = '0;
        endcase
    end
endmodule

// File: rtl/dual_alu_exec.sv
module dual_alu_exec
    import dalu_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [4:0]        op0,
    input  logic [4:0]        op1,
    input  logic [4:0]        sa0,
    input  logic [4:0]        sb0,
    input  logic [4:0]        sa1,
    input  logic [4:0]        sb1,
    input  logic [4:0]        dst0,
    input  logic [4:0]        dst1,
    input  logic [15:0]       imm0,
    input  logic [15:0]       imm1,
    input  logic [31:0]       ld0,
    input  logic [31:0]       ld1,
    output logic              state_req,
    output logic [17:0]       state_addr,
    input  logic [31:0]       state_rdata,
    output logic              mem_rd_req,
    output logic              mem_wr_req,
    output logic [31:0]       mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    output logic              sync_req,
    output logic              out_valid,
    output logic [31:0]       res0,
    output logic [31:0]       res1,
    output logic              wr0_en,
    output logic [4:0]        wr0_idx,
    output logic              wr1_en,
    output logic [4:0]        wr1_idx
);
    typedef logic [NREGS-1:0][DW-1:0] rfile_t;

    typedef struct packed {
        logic             valid;
        logic [DW-1:0]    res0;
        logic [DW-1:0]    res1;
        logic             wr0;
        logic [SEL_W-1:0] idx0;
        logic             wr1;
        logic [SEL_W-1:0] idx1;
        logic [DW-1:0]    carry;
        rfile_t           regs;
    } exec_t;

    exec_t d, q;

    alu_op_e       opc0, opc1;
    logic [DW-1:0] x0, y0, x1, y1;
    logic [DW-1:0] r0_c, r1_c, cnx0, cnx1, carry_mid;
    logic          cwe0, cwe1;
    logic          dst0_live, dst1_live;
    rfile_t        regs_fwd;
    logic [DW-1:0] st_sum;

    assign opc0      = alu_op_e'(op0);
    assign opc1      = alu_op_e'(op1);
    assign dst0_live = in_valid && (dst0 < SEL_W'(NREGS));
    assign dst1_live = in_valid && (dst1 < SEL_W'(NREGS));

    // ---------------- unit 0 -----------------
    dalu_operand #(.DW(DW), .IMM_W(IMM_W), .SEL_W(SEL_W), .NREGS(NREGS)) u_opx0 (
        .sel(sa0), .regs(q.regs), .imm_own(imm0), .imm_other(imm1),
        .imm_hi(imm0), .imm_lo(imm1), .ld0(ld0), .ld1(ld1), .val(x0));
    dalu_operand #(.DW(DW), .IMM_W(IMM_W), .SEL_W(SEL_W), .NREGS(NREGS)) u_opy0 (
        .sel(sb0), .regs(q.regs), .imm_own(imm0), .imm_other(imm1),
        .imm_hi(imm0), .imm_lo(imm1), .ld0(ld0), .ld1(ld1), .val(y0));
    dalu_core u_core0 (
        .op(opc0), .x(x0), .y(y0), .imm(imm0), .carry_in(q.carry),
        .state_rdata(state_rdata), .mem_rdata(mem_rdata),
        .res(r0_c), .carry_we(cwe0), .carry_nx(cnx0));

    // forward unit 0's write and carry into unit 1
    always_comb begin
        regs_fwd  = q.regs;
        for (int i = 0; i < NREGS; i++) begin
            if (dst0_live && dst0 == SEL_W'(i)) regs_fwd[i] = r0_c;
        end
        carry_mid = (in_valid && cwe0) ? cnx0 : q.carry;
    end

    // ---------------- unit 1 -----------------
    dalu_operand #(.DW(DW), .IMM_W(IMM_W), .SEL_W(SEL_W), .NREGS(NREGS)) u_opx1 (
        .sel(sa1), .regs(regs_fwd), .imm_own(imm1), .imm_other(imm0),
        .imm_hi(imm0), .imm_lo(imm1), .ld0(ld0), .ld1(ld1), .val(x1));
    dalu_operand #(.DW(DW), .IMM_W(IMM_W), .SEL_W(SEL_W), .NREGS(NREGS)) u_opy1 (
        .sel(sb1), .regs(regs_fwd), .imm_own(imm1), .imm_other(imm0),
        .imm_hi(imm0), .imm_lo(imm1), .ld0(ld0), .ld1(ld1), .val(y1));
    dalu_core u_core1 (
        .op(opc1), .x(x1), .y(y1), .imm(imm1), .carry_in(carry_mid),
        .state_rdata(state_rdata), .mem_rdata(mem_rdata),
        .res(r1_c), .carry_we(cwe1), .carry_nx(cnx1));

    // ---------------- request ports -----------------
    always_comb begin
        st_sum     = (opc0 == OP_STATE) ? (x0 + y0) : (x1 + y1);
        state_req  = in_valid && (opc0 == OP_STATE || opc1 == OP_STATE);
        state_addr = {st_sum[IMM_W-1:0], 2'b00};
        mem_rd_req = in_valid && (opc0 == OP_MRD || opc1 == OP_MRD);
        mem_wr_req = in_valid && (opc0 == OP_MWR || opc1 == OP_MWR);
        sync_req   = in_valid && (opc0 == OP_SYNC || opc1 == OP_SYNC);
        if (opc0 == OP_MRD || opc0 == OP_MWR) begin
            mem_addr  = x0;
            mem_wdata = y0;
        end else begin
            mem_addr  = x1;
            mem_wdata = y1;
        end
    end

    // ---------------- next state -----------------
    always_comb begin
        d       = q;
        d.valid = in_valid;
        d.wr0   = 1'b0;
        d.wr1   = 1'b0;
        if (in_valid) begin
            d.res0 = r0_c;
            d.res1 = r1_c;
            d.wr0  = dst0_live;
            d.wr1  = dst1_live;
            d.idx0 = dst0;
            d.idx1 = dst1;
            d.carry = cwe1 ? cnx1 : carry_mid;
            d.regs = regs_fwd;
            for (int i = 0; i < NREGS; i++) begin
                if (dst1_live && dst1 == SEL_W'(i)) d.regs[i] = r1_c;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign out_valid = q.valid;
    assign res0      = q.res0;
    assign res1      = q.res1;
    assign wr0_en    = q.wr0;
    assign wr0_idx   = q.idx0;
    assign wr1_en    = q.wr1;
    assign wr1_idx   = q.idx1;

    // ---------------- assertions -----------------
    AST_VALID_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr0_en && !wr1_en)); // R1
    AST_DROP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && dst0 >= 5'd24) |=> !wr0_en); // R3
    AST_CARRY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(q.carry)); // R14
    AST_ONE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> !(opc0 == OP_STATE && opc1 == OP_STATE)); // R12
    AST_CMP_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (opc0 == OP_SLT || opc0 == OP_SLTU || opc0 == OP_SLE ||
                      opc0 == OP_SLEU || opc0 == OP_SEQ))
        |-> (r0_c == '0 || r0_c == '1)); // R11
    AST_CLZ_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && opc0 == OP_CLZ && x0 == '0) |-> (r0_c == DW'(DW))); // R8
endmodule

// File: tb/dual_alu_exec_bench.sv
`timescale 1ns/1ps
module dual_alu_exec_bench;
    localparam logic [4:0] ADD=0, ADDC=1, SUB=2, SUBB=3, MUL=4, MULU=5, MULH=6, CLZ=7,
        SLL=8, SRL=9, SRA=10, AND=11, NAND=12, OR=13, XOR=14, MERGE=15, SLT=16, SLTU=17,
        SLE=18, SLEU=19, SEQ=20, STATE=21, MRD=22, MWR=23, SYNC=24;
    localparam logic [4:0] Z=24, I=25, P=26, W=27, L0=28, L1=29, DN=24;

    typedef struct packed {
        logic [4:0]  o0, o1, a0, b0, a1, b1, d0, d1;
        logic [15:0] i0, i1;
        logic [31:0] l0, l1, e0, e1;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VT [NV] = '{
        '{ADD,  ADDC, L0, L1, Z,  Z,  DN, DN, 16'h0000, 16'h0000, 32'hFFFFFFFF, 32'h00000002, 32'h00000001, 32'h00000001}, // R4
        '{SUB,  SUBB, L0, L1, Z,  Z,  DN, DN, 16'h0000, 16'h0000, 32'h00000000, 32'h00000001, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R5
        '{SUB,  SUBB, L0, L1, Z,  Z,  DN, DN, 16'h0000, 16'h0000, 32'h00000005, 32'h00000003, 32'h00000002, 32'h00000000}, // R5
        '{MUL,  MULH, I,  L0, Z,  Z,  DN, DN, 16'hFFFE, 16'h0000, 32'h00000003, 32'h00000000, 32'hFFFFFFFA, 32'hFFFFFFFF}, // R6
        '{MULU, MULH, L0, L1, Z,  Z,  DN, DN, 16'h0000, 16'h0000, 32'hFFFFFFFF, 32'h00000002, 32'hFFFFFFFE, 32'h00000001}, // R6
        '{MULH, AND,  Z,  Z,  Z,  Z,  DN, DN, 16'h0000, 16'h0000, 32'h00000000, 32'h00000000, 32'h00000001, 32'h00000000}, // R14
        '{SLL,  SRA,  L0, I,  L1, I,  DN, DN, 16'h0024, 16'h0021, 32'h00000001, 32'h80000000, 32'h00000010, 32'hC0000000}, // R7
        '{SRL,  CLZ,  L0, I,  L1, Z,  DN, DN, 16'h001F, 16'h0000, 32'h80000000, 32'h00000000, 32'h00000001, 32'h00000020}, // R7 R8
        '{CLZ,  CLZ,  L0, Z,  L1, Z,  DN, DN, 16'h0000, 16'h0000, 32'h00010000, 32'hFFFFFFFF, 32'h0000000F, 32'h00000000}, // R8
        '{AND,  NAND, L0, L1, L0, L1, DN, DN, 16'h0000, 16'h0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hF000F000, 32'h0FFF0FFF}, // R9
        '{OR,   XOR,  L0, L1, L0, L1, DN, DN, 16'h0000, 16'h0000, 32'hF0F0F0F0, 32'hFF00FF00, 32'hFFF0FFF0, 32'h0FF00FF0}, // R9
        '{MERGE,MERGE,L0, L1, Z,  L1, DN, DN, 16'h2084, 16'h7904, 32'hFFFFFFFF, 32'h000000A0, 32'hFFFFFAFF, 32'h80000000}, // R10
        '{SLT,  SLTU, L0, L1, L0, L1, DN, DN, 16'h0000, 16'h0000, 32'hFFFFFFFF, 32'h00000001, 32'hFFFFFFFF, 32'h00000000}, // R11
        '{SLE,  SEQ,  L0, L1, P,  L0, DN, DN, 16'h0005, 16'h0000, 32'h00000005, 32'h00000005, 32'hFFFFFFFF, 32'hFFFFFFFF}, // R11 R2
        '{SLEU, SEQ,  L0, L1, W,  L0, DN, DN, 16'hFFFF, 16'hFFFF, 32'hFFFFFFFF, 32'h00000001, 32'h00000000, 32'hFFFFFFFF}, // R11 R2
        '{STATE,AND,  I,  L0, Z,  Z,  DN, DN, 16'h0010, 16'h0000, 32'hFFFF0001, 32'h00000000, 32'hA5000044, 32'h00000000}, // R12
        '{ADD,  MRD,  Z,  Z,  L1, Z,  DN, DN, 16'h0000, 16'h0000, 32'h00000000, 32'h00001234, 32'h00000000, 32'h0F0F1234}, // R13
        '{ADD,  ADD,  P,  Z,  P,  Z,  DN, DN, 16'h8000, 16'h7FFF, 32'h00000000, 32'h00000000, 32'h00007FFF, 32'hFFFF8000}  // R2
    };

    logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0;
    logic [4:0] op0 = '0, op1 = '0, sa0 = Z, sb0 = Z, sa1 = Z, sb1 = Z, dst0 = DN, dst1 = DN;
    logic [15:0] imm0 = '0, imm1 = '0;
    logic [31:0] ld0 = '0, ld1 = '0;
    logic state_req, mem_rd_req, mem_wr_req, sync_req, out_valid, wr0_en, wr1_en;
    logic [17:0] state_addr;
    logic [31:0] state_rdata, mem_addr, mem_wdata, mem_rdata, res0, res1;
    logic [4:0] wr0_idx, wr1_idx;
    int n_chk = 0, n_bad = 0;

    always #4 clk = ~clk;

    assign state_rdata = {14'b0, state_addr} ^ 32'hA500_0000;
    assign mem_rdata   = mem_addr ^ 32'h0F0F_0000;

    dual_alu_exec u_dual_alu_exec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op0(op0), .op1(op1),
        .sa0(sa0), .sb0(sb0), .sa1(sa1), .sb1(sb1), .dst0(dst0), .dst1(dst1),
        .imm0(imm0), .imm1(imm1), .ld0(ld0), .ld1(ld1),
        .state_req(state_req), .state_addr(state_addr), .state_rdata(state_rdata),
        .mem_rd_req(mem_rd_req), .mem_wr_req(mem_wr_req), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .sync_req(sync_req),
        .out_valid(out_valid), .res0(res0), .res1(res1),
        .wr0_en(wr0_en), .wr0_idx(wr0_idx), .wr1_en(wr1_en), .wr1_idx(wr1_idx));

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        op0 = v.o0; op1 = v.o1; sa0 = v.a0; sb0 = v.b0; sa1 = v.a1; sb1 = v.b1;
        dst0 = v.d0; dst1 = v.d1; imm0 = v.i0; imm1 = v.i1; ld0 = v.l0; ld1 = v.l1;
    endtask

    task automatic settle();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
            dst0 = 5'd5;
            op0 = ADD; sa0 = I; imm0 = 16'h0063;
            settle();
        end
    endtask

    initial begin
        #(200000 * 8);
        n_bad++;
        n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R14 reset out_valid", 32'(out_valid), 0);
        check("R14 reset res0", res0, 0);
        check("R14 reset wr flags", {30'b0, wr0_en, wr1_en}, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // registers and carry are clear after reset
        put('{MULH, OR, Z, Z, 5'd5, Z, DN, DN, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 32'h0});
        settle();
        check("R14 carry after reset", res0, 0);
        check("R14 register after reset", res1, 0);
        check("R1 out_valid after instruction", 32'(out_valid), 1);

        // vector table
        for (int v = 0; v < NV; v++) begin
            put(VT[v]);
            settle();
            check($sformatf("vector %0d res0", v), res0, VT[v].e0);
            check($sformatf("vector %0d res1", v), res1, VT[v].e1);
        end

        // R3 same-instruction forwarding and writes
        put('{ADD, ADD, I, Z, 5'd3, I, 5'd3, 5'd4, 16'h0007, 16'h0001, 32'h0, 32'h0, 32'h0, 32'h0});
        settle();
        check("R3 forwarded res1", res1, 32'h8);
        check("R3 wr0 flag/idx", {26'b0, wr0_en, wr0_idx}, {26'b0, 1'b1, 5'd3});
        check("R3 wr1 flag/idx", {26'b0, wr1_en, wr1_idx}, {26'b0, 1'b1, 5'd4});
        put('{OR, OR, 5'd3, Z, 5'd4, Z, DN, 5'd31, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 32'h0});
        settle();
        check("R3 r3 readback", res0, 32'h7);
        check("R3 r4 readback", res1, 32'h8);
        check("R3 discarded dst flags", {30'b0, wr0_en, wr1_en}, 0);

        // R1 / R14 idle cycles hold carry and registers
        put('{ADD, AND, L0, L1, Z, Z, DN, DN, 16'h0, 16'h0, 32'hFFFFFFFF, 32'h1, 32'h0, 32'h0});
        settle();
        idle(3);
        check("R1 out_valid low when idle", 32'(out_valid), 0);
        check("R1 no write when idle", {30'b0, wr0_en, wr1_en}, 0);
        put('{MULH, OR, Z, Z, 5'd5, Z, DN, DN, 16'h0, 16'h0, 32'h0, 32'h0, 32'h0, 32'h0});
        settle();
        check("R14 carry held over idle", res0, 32'h1);
        check("R1 idle cycle wrote no register", res1, 32'h0);

        // R12 request port
        put('{STATE, AND, I, L0, Z, Z, DN, DN, 16'h0003, 16'h0, 32'h0001_FFFE, 32'h0, 32'h0, 32'h0});
        #1;
        check("R12 state_req", 32'(state_req), 1);
        check("R12 state_addr wraps", 32'(state_addr), 32'h4);
        settle();

        // R13 memory write by unit 1 and sync by unit 0
        put('{SYNC, MWR, Z, Z, L0, L1, DN, DN, 16'h0, 16'h0, 32'h40, 32'hDEAD, 32'h0, 32'h0});
        #1;
        check("R13 mem_wr_req", 32'(mem_wr_req), 1);
        check("R13 mem_addr", mem_addr, 32'h40);
        check("R13 mem_wdata", mem_wdata, 32'hDEAD);
        check("R13 sync_req", 32'(sync_req), 1);
        check("R13 mem_rd_req low", 32'(mem_rd_req), 0);
        settle();
        @(negedge clk);
        in_valid = 1'b0;
        #1;
        check("R13 no request while idle", {29'b0, state_req, mem_wr_req, sync_req}, 0);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule